// File: doc/BRIEF.md
# Vector Shift-and-Insert Unit

This unit performs a lane-wise immediate shift on a 128-bit source vector and merges each shifted lane into the previous contents of the destination. Only the bit positions that actually receive shifted source bits are written. The positions that the shift empties keep the old destination bits. In left mode these are the low n bits of each lane. In right mode they are the high n bits. The lanes are 8, 16 or 32 bits wide, which gives 16, 8 or 4 lanes.

The caller presents the old destination, the source, a lane-size code, a direction, a shift amount and an optional per-lane predicate, together with a valid strobe. One clock later the merged vector appears on a registered output. An out-of-range operand raises an illegal flag and passes the old destination through unchanged.

Top module: `vec_shift_insert`

## Requirements
- R1: `lane_size` selects the lane width: code 0 gives 8 bits, code 1 gives 16 bits and code 2 gives 32 bits. Lane k occupies bits [k*W +: W] of every vector.
- R2: With `dir_right`=0 (left insert) and shift n, bit b of each lane becomes source bit b-n of the same lane when b >= n. When b < n, it keeps the old destination bit.
- R3: With `dir_right`=1 (right insert) and shift n, bit b of each lane becomes source bit b+n of the same lane when b < W-n. The top n bits keep the old destination bits.
- R4: A shift equal to the lane width is legal. It leaves every lane equal to the old destination lane, and `illegal` stays 0.
- R5: When `pred_en`=1, a lane k with `pred[k]`=0 keeps its old destination value. When `pred_en`=0, the predicate bits have no effect.
- R6: A shift of 0, a shift above W, or `lane_size` code 3 sets `illegal` to 1, and the result equals the old destination vector.
- R7: Results are registered. When `in_valid` is high on an edge, `dst_out` and `illegal` update at that edge and `out_valid` goes to 1. When `in_valid` is low on an edge, `dst_out` holds its value and both `illegal` and `out_valid` go to 0.
- R8: On a synchronous active-low reset, `dst_out` is zero and both `out_valid` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| old_dst | input | 128 | Previous destination vector |
| src | input | 128 | Source vector to shift |
| lane_size | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: reserved |
| dir_right | input | 1 | 0: left insert, 1: right insert |
| shamt | input | 6 | Immediate shift amount |
| pred_en | input | 1 | Apply the per-lane predicate |
| pred | input | 16 | Per-lane enable, bit k for lane k |
| dst_out | output | 128 | Merged destination vector |
| out_valid | output | 1 | `dst_out` holds a fresh result |
| illegal | output | 1 | Last operation had an illegal operand |

## Verification
On every cycle, the assertions check the following:
- the valid pipeline and the reset state;
- the illegal passthrough;
- the preservation of emptied bit positions in lane 0 for both directions;
- that a masked-off lane keeps its old value.

Only the bench's scenarios can show the following:
- that the written bits hold the correct shifted source bits in every lane and every width;
- that lane boundaries are respected;
- that the predicate is ignored when disabled;
- that the output holds across idle cycles.

// File: rtl/vsi_pkg.sv
// Shared definitions for the vector shift-and-insert unit.
// Assumes a vector whose width is a multiple of 32 bits.
package vsi_pkg;
    typedef enum logic [1:0] {
        LS_B8  = 2'd0,
        LS_B16 = 2'd1,
        LS_B32 = 2'd2,
        LS_RSV = 2'd3
    } lane_size_e;

    // Lane width in bits for a legal size code.
    function automatic int unsigned lane_bits(input logic [1:0] code);
        return 32'd8 << code;
    endfunction
endpackage

// File: rtl/vsi_check.sv
// Operand legality check. It flags a reserved size code, a zero shift,
// or a shift that exceeds the selected lane width.
// Assumes that SH_W is wide enough to hold the largest lane width.
module vsi_check #(
    parameter int SH_W = 6
) (
    input  logic [1:0]      size_code,
    input  logic [SH_W-1:0] amt,
    output logic            bad
);
    import vsi_pkg::*;

    // Compare the shift against the width of the selected lane.
    always_comb begin
        if (size_code == LS_RSV) begin
            bad = 1'b1;
        end else begin
            bad = (amt == '0) || (int'(amt) > int'(lane_bits(size_code)));
        end
    end
endmodule

// File: rtl/vsi_lane.sv
// One lane of shift-and-insert. It shifts src_l by amt, builds the insert
// mask as all-ones shifted the same way, and merges with old_l.
// Assumes that the caller checks legality; hold forces old_l through.
module vsi_lane #(
    parameter int LW   = 8,
    parameter int SH_W = 6
) (
    input  logic [LW-1:0]   old_l,
    input  logic [LW-1:0]   src_l,
    input  logic [SH_W-1:0] amt,
    input  logic            go_right,
    input  logic            hold,
    output logic [LW-1:0]   res_l
);
    logic [LW-1:0] shifted;
    logic [LW-1:0] ins_mask;

    // Shift the source lane and the all-ones mask in the chosen direction.
    always_comb begin
        if (go_right) begin
            shifted  = src_l >> amt;
            ins_mask = {LW{1'b1}} >> amt;
        end else begin
            shifted  = src_l << amt;
            ins_mask = {LW{1'b1}} << amt;
        end
    end

    // Merge the shifted bits into the old lane, or keep the old lane when held.
    always_comb begin
        if (hold) res_l = old_l;
        else      res_l = (shifted & ins_mask) | (old_l & ~ins_mask);
    end
endmodule

// File: rtl/vec_shift_insert.sv
// Vector shift-and-insert top. It builds results for all three lane widths
// in parallel, selects one by size code, and registers it.
// Assumes that VEC_W is a multiple of 32 and that the predicate has one bit per 8-bit lane.
module vec_shift_insert #(
    parameter int VEC_W = 128,
    parameter int SH_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [VEC_W-1:0]     old_dst,
    input  logic [VEC_W-1:0]     src,
    input  logic [1:0]           lane_size,
    input  logic                 dir_right,
    input  logic [SH_W-1:0]      shamt,
    input  logic                 pred_en,
    input  logic [VEC_W/8-1:0]   pred,
    output logic [VEC_W-1:0]     dst_out,
    output logic                 out_valid,
    output logic                 illegal
);
    import vsi_pkg::*;

    localparam int N_SIZES = 3;

    logic [N_SIZES-1:0][VEC_W-1:0] res_w;
    logic                          bad_op;
    logic [VEC_W-1:0]              next_dst;

    vsi_check #(.SH_W(SH_W)) u_chk (
        .size_code (lane_size),
        .amt       (shamt),
        .bad       (bad_op)
    );

    for (genvar gi = 0; gi < N_SIZES; gi++) begin : g_size
        localparam int LW = 8 << gi;
        localparam int NL = VEC_W / LW;
        for (genvar li = 0; li < NL; li++) begin : g_lane
            vsi_lane #(.LW(LW), .SH_W(SH_W)) u_lane (
                .old_l    (old_dst[li*LW +: LW]),
                .src_l    (src[li*LW +: LW]),
                .amt      (shamt),
                .go_right (dir_right),
                .hold     (pred_en & ~pred[li]),
                .res_l    (res_w[gi][li*LW +: LW])
            );
        end
    end

    // Pick the result for the selected width, or pass the old value through on an illegal operand.
    always_comb begin
        if (bad_op) next_dst = old_dst;
        else        next_dst = res_w[lane_size];
    end

    // Register the result, the valid flag and the illegal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_out   <= '0;
            out_valid <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            illegal   <= in_valid & bad_op;
            if (in_valid) dst_out <= next_dst;
        end
    end

    // R7
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R6
    illegal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (out_valid && dst_out == $past(old_dst)));

    // R2
    left_keep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bad_op && !dir_right && lane_size == LS_B8 && !pred_en)
        |=> (((dst_out[7:0] ^ $past(old_dst[7:0])) & ~(8'hFF << $past(shamt))) == 8'h00));

    // R3
    right_keep_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bad_op && dir_right && lane_size == LS_B8 && !pred_en)
        |=> (((dst_out[7:0] ^ $past(old_dst[7:0])) & ~(8'hFF >> $past(shamt))) == 8'h00));

    // R5
    pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_en && !pred[0])
        |=> (dst_out[7:0] == $past(old_dst[7:0])));

    // R8
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && !illegal && dst_out == '0));
endmodule

// File: tb/sim_vec_shift_insert.sv
module sim_vec_shift_insert;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] old_dst = '0;
    logic [127:0] src = '0;
    logic [1:0]   lane_size = 2'd0;
    logic         dir_right = 1'b0;
    logic [5:0]   shamt = 6'd0;
    logic         pred_en = 1'b0;
    logic [15:0]  pred = '0;
    logic [127:0] dst_out;
    logic         out_valid;
    logic         illegal;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    vec_shift_insert u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .old_dst(old_dst),
        .src(src), .lane_size(lane_size), .dir_right(dir_right),
        .shamt(shamt), .pred_en(pred_en), .pred(pred),
        .dst_out(dst_out), .out_valid(out_valid), .illegal(illegal)
    );

    // Bit-by-bit behavioural model of the requirements.
    function automatic logic [127:0] model(input logic [127:0] o, input logic [127:0] s,
                                           input int sz, input int rt, input int n,
                                           input int pe, input logic [15:0] p);
        logic [127:0] r = o;
        int w;
        if (sz == 3) return o;
        w = 8 << sz;
        if (n < 1 || n > w) return o;
        for (int k = 0; k < 128 / w; k++) begin
            if (pe != 0 && !p[k]) continue;
            for (int b = 0; b < w; b++) begin
                if (rt == 0) begin
                    if (b >= n) r[k*w + b] = s[k*w + b - n];
                end else begin
                    if (b + n < w) r[k*w + b] = s[k*w + b + n];
                end
            end
        end
        return r;
    endfunction

    function automatic bit is_bad(input int sz, input int n);
        if (sz == 3) return 1'b1;
        return (n < 1 || n > (8 << sz));
    endfunction

    task automatic check(input string tag, input logic [127:0] exp_d,
                         input logic exp_v, input logic exp_i);
        vectors++;
        if (dst_out !== exp_d || out_valid !== exp_v || illegal !== exp_i) begin
            miscompares++;
            $display("FAIL %s: dst=%h v=%b ill=%b expected dst=%h v=%b ill=%b",
                     tag, dst_out, out_valid, illegal, exp_d, exp_v, exp_i);
        end
    endtask

    task automatic apply(input string tag, input logic [127:0] o, input logic [127:0] s,
                         input int sz, input int rt, input int n,
                         input int pe, input logic [15:0] p);
        logic [127:0] e;
        @(negedge clk);
        in_valid = 1'b1; old_dst = o; src = s; lane_size = sz[1:0];
        dir_right = rt[0]; shamt = n[5:0]; pred_en = pe[0]; pred = p;
        e = model(o, s, sz, rt, n, pe, p);
        @(posedge clk); #1;
        check(tag, e, 1'b1, is_bad(sz, n));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset", '0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4: all widths, both directions, corner and middle shifts
        for (int sz = 0; sz < 3; sz++) begin
            for (int rt = 0; rt < 2; rt++) begin
                int w = 8 << sz;
                int amts[5] = '{1, 2, w/2, w-1, w};
                for (int a = 0; a < 5; a++) begin
                    for (int t = 0; t < 3; t++) begin
                        apply(amts[a] == w ? "R4 full shift" : (rt == 0 ? "R2 left" : "R3 right"),
                              rnd128(), rnd128(), sz, rt, amts[a], 0, 16'h0000);
                    end
                end
                // R1 lane boundary: all-ones source over zero destination
                apply("R1 boundaries", '0, {128{1'b1}}, sz, rt, 1, 0, 16'h0);
            end
        end

        // R5: predicate masks lanes; disabled predicate is ignored
        for (int sz = 0; sz < 3; sz++) begin
            apply("R5 pred on", rnd128(), rnd128(), sz, 0, 3, 1, 16'hA5C3);
            apply("R5 pred on", rnd128(), rnd128(), sz, 1, 5, 1, 16'h0F0A);
            apply("R5 pred off", rnd128(), rnd128(), sz, 0, 4, 0, 16'h0000);
            apply("R5 pred none", rnd128(), rnd128(), sz, 1, 2, 1, 16'h0000);
        end

        // R6: illegal operands pass the old destination through
        apply("R6 zero shift", rnd128(), rnd128(), 0, 0, 0, 0, 16'h0);
        apply("R6 over 8", rnd128(), rnd128(), 0, 1, 9, 0, 16'h0);
        apply("R6 over 16", rnd128(), rnd128(), 1, 0, 17, 0, 16'h0);
        apply("R6 over 32", rnd128(), rnd128(), 2, 1, 33, 0, 16'h0);
        apply("R6 reserved", rnd128(), rnd128(), 3, 0, 4, 0, 16'h0);

        // R7: idle cycles hold data and clear the flags
        apply("R7 setup", rnd128(), rnd128(), 1, 0, 6, 0, 16'h0);
        held = dst_out;
        apply("R7 illegal", rnd128(), rnd128(), 2, 0, 0, 0, 16'h0);
        held = dst_out;
        @(negedge clk);
        in_valid = 1'b0; old_dst = rnd128(); src = rnd128(); shamt = 6'd3; lane_size = 2'd0;
        @(posedge clk); #1;
        check("R7 idle hold", held, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R7 idle hold 2", held, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule